// File: doc/BRIEF.md
# Ultra DMA Device Write-Burst Controller

This block is the device-side control for a parallel-ATA Ultra DMA data-out burst, where the host writes to the device. When local logic raises `xfer_req`, the block asserts `dmarq`. Once the host acknowledges by pulling `dmack_n` low, it drives its active-low ready line. Every data-carrying transition of `hstrobe`, rising or falling, delivers one 16-bit word from `dd`. Each word is folded into a running CRC and placed in a small elastic buffer. That buffer feeds a valid/ready stream towards the rest of the device.

A burst ends in one of two ways. The device can start the end with `end_req`, once at least one word has arrived: ready goes high first and `dmarq` follows a fixed number of cycles later. The host can start the end with `stop`. In both cases the host's final strobe transition carries no data and is dropped. When `dmack_n` returns high, the host CRC present on `dd` is compared with the device's own CRC. The first mismatch of a command is kept until `cmd_clr`.

Stream rules: a word is handed over in each cycle where `m_valid` and `m_ready` are both high. While `m_valid` is high and `m_ready` is low, `m_data` holds its value. `m_valid` does not depend combinationally on `m_ready`. When the consumer holds back, the buffer fills and the block pauses the host by raising its ready line. Two buffer slots stay in reserve for the words the host may still send after that.

Top module: `udma_wr_dev`

## Requirements
- R1: After reset, `dmarq` is 0, `dmardy_oe` is 0, `dmardy_n` is 1, `m_valid` is 0 and `crc_err` is 0.
- R2: `xfer_req` sampled high while idle raises `dmarq` one cycle later. `dmack_n` sampled low while `dmarq` is high makes `dmardy_oe` 1 and `dmardy_n` 0 one cycle later.
- R3: Each `hstrobe` transition, in either direction, that is sampled during the data phase delivers the word on `dd` to the stream output once, in arrival order.
- R4: `dmardy_n` is 1 while the buffer holds more than DEPTH-3 words, and it returns to 0 once the buffer drains. The two words that arrive after the pause starts are kept without loss.
- R5: `end_req` is ignored until the burst has delivered at least one word: `dmarq` stays 1 and `dmardy_n` stays 0.
- R6: `end_req` after at least one word makes `dmardy_n` 1 one cycle later. `dmarq` falls exactly TRP cycles after that. Words that arrive between these two events are accepted.
- R7: `stop` sampled high during the data phase makes `dmarq` 0 and `dmardy_n` 1 one cycle later.
- R8: `hstrobe` transitions after `dmarq` has fallen deliver no word and leave the CRC unchanged.
- R9: The CRC uses polynomial 0x1021 and processes each word MSB first. It is seeded with 0x4ABA at the start of every burst. When `dmack_n` rises at the end of a burst, `dd` is compared with the CRC, and a mismatch sets `crc_err`.
- R10: `err_crc` holds the host CRC of the first mismatch. Later mismatches change neither `crc_err` nor `err_crc`. `cmd_clr` clears `crc_err`.
- R11: `dmardy_oe` stays 1 until `dmack_n` rises at burst end, and it is 0 one cycle after that rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_req | input | 1 | Local request to start a burst |
| end_req | input | 1 | Local request to end the burst |
| cmd_clr | input | 1 | Command start, clears the error flag |
| dmack_n | input | 1 | Host acknowledge, active low |
| stop | input | 1 | Host stop request |
| hstrobe | input | 1 | Host data strobe |
| dd | input | 16 | Data bus, carries the host CRC at burst end |
| dmarq | output | 1 | Device DMA request |
| dmardy_n | output | 1 | Device ready, active low |
| dmardy_oe | output | 1 | Drive enable for the ready line |
| m_valid | output | 1 | Stream word valid |
| m_data | output | 16 | Stream word |
| m_ready | input | 1 | Stream consumer ready |
| crc_err | output | 1 | Sticky CRC mismatch flag |
| err_crc | output | 16 | Host CRC of the first mismatch |

## Verification
Every control output is a register or decodes registered state. A stimulus sampled at one rising edge therefore shows on the outputs right after that edge, so `dmarq`, `dmardy_n`, `dmardy_oe`, `m_valid` and the error flag are all due one cycle after the input that causes them. The one exception is the `dmarq` fall in a device-ended burst, which is due TRP cycles after the ready rise. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so every check lands half a cycle after the edge that should have changed the output. For the TRP window, it checks that `dmarq` is still high at the last cycle before the deadline and low at the deadline.

// File: rtl/udma_wr_pkg.sv
`timescale 1ns/1ps
package udma_wr_pkg;
  localparam int WORD_W = 16;
  localparam logic [WORD_W-1:0] CRC_POLY = 16'h1021;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_BURST,
    S_DEVEND,
    S_WAITACK
  } udma_st_e;

  // One word folded MSB first into the CRC register.
  function automatic logic [WORD_W-1:0] crc_fold(input logic [WORD_W-1:0] c,
                                                 input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    logic fb;
    r = c;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = r[WORD_W-1] ^ w[i];
      r  = {r[WORD_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return r;
  endfunction
endpackage

// File: rtl/udma_wr_crc.sv
`timescale 1ns/1ps
module udma_wr_crc
  import udma_wr_pkg::*;
#(
  parameter logic [WORD_W-1:0] SEED = 16'h4ABA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_ld,
  input  logic              upd,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc <= SEED;
    else if (seed_ld) crc <= SEED;
    else if (upd)     crc <= crc_fold(crc, word);
  end
endmodule

// File: rtl/udma_wr_fifo.sv
`timescale 1ns/1ps
module udma_wr_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  output logic [$clog2(DEPTH):0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULL = (AW + 1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_en) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R4: the reserve of two slots must keep trailing words from overflowing
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (count < FULL || rd_en));
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (count != '0));
endmodule

// File: rtl/udma_wr_ctrl.sv
`timescale 1ns/1ps
module udma_wr_ctrl
  import udma_wr_pkg::*;
#(
  parameter int TRP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_req,
  input  logic              end_req,
  input  logic              cmd_clr,
  input  logic              dmack_n,
  input  logic              stop,
  input  logic              hstrobe,
  input  logic [WORD_W-1:0] dd,
  input  logic              fifo_hi,
  input  logic [WORD_W-1:0] crc_val,
  output logic              dmarq,
  output logic              rdy_n,
  output logic              rdy_oe,
  output logic              wr_en,
  output logic              crc_seed,
  output logic              crc_err,
  output logic [WORD_W-1:0] err_crc,
  output udma_st_e          st
);
  localparam int TW = $clog2(TRP + 1);
  localparam logic [TW-1:0] TRP_LOAD = TW'(TRP - 1);

  udma_st_e  nxt;
  logic      hs_q;
  logic      word_seen;
  logic [TW-1:0] trp_cnt;
  logic      chk;

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE:    if (xfer_req) nxt = S_REQ;
      S_REQ:     if (!dmack_n) nxt = S_BURST;
      S_BURST: begin
        if (dmack_n)                     nxt = S_IDLE;
        else if (stop)                   nxt = S_WAITACK;
        else if (end_req && word_seen)   nxt = S_DEVEND;
      end
      S_DEVEND: begin
        if (dmack_n)             nxt = S_IDLE;
        else if (trp_cnt == '0)  nxt = S_WAITACK;
      end
      S_WAITACK: if (dmack_n) nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  assign wr_en    = (hstrobe ^ hs_q) && !dmack_n && (st == S_BURST || st == S_DEVEND);
  assign crc_seed = (st == S_REQ) && !dmack_n;
  assign dmarq    = (st == S_REQ) || (st == S_BURST) || (st == S_DEVEND);
  assign rdy_n    = !((st == S_BURST) && !fifo_hi);
  assign rdy_oe   = (st == S_BURST) || (st == S_DEVEND) || (st == S_WAITACK);
  assign chk      = (st == S_WAITACK) && dmack_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      hs_q      <= 1'b0;
      word_seen <= 1'b0;
      trp_cnt   <= '0;
      crc_err   <= 1'b0;
      err_crc   <= '0;
    end else begin
      st   <= nxt;
      hs_q <= hstrobe;
      if (st == S_IDLE)  word_seen <= 1'b0;
      else if (wr_en)    word_seen <= 1'b1;
      if (st == S_BURST)                         trp_cnt <= TRP_LOAD;
      else if (st == S_DEVEND && trp_cnt != '0)  trp_cnt <= trp_cnt - 1'b1;
      if (cmd_clr) crc_err <= 1'b0;
      else if (chk && (dd != crc_val) && !crc_err) begin
        crc_err <= 1'b1;
        err_crc <= dd;
      end
    end
  end

  // Cycles with ready high while the request is still up, for the TRP check.
  logic [15:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         hi_cnt <= '0;
    else if (!dmarq || !rdy_n)          hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF)        hi_cnt <= hi_cnt + 1'b1;
  end

  p_trp_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dmarq) && !$past(stop) && !$past(dmack_n)) |-> (hi_cnt >= 16'(TRP)));
  p_stop_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BURST && stop && !dmack_n) |=> (!dmarq && rdy_n));
  p_early_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BURST && end_req && !word_seen && !stop && !dmack_n) |=> (dmarq && st == S_BURST));
  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAITACK && dmack_n) |=> !rdy_oe);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && !cmd_clr) |=> (crc_err && $stable(err_crc)));
endmodule

// File: rtl/udma_wr_dev.sv
`timescale 1ns/1ps
module udma_wr_dev
  import udma_wr_pkg::*;
#(
  parameter int          DEPTH = 8,
  parameter int          TRP   = 4,
  parameter logic [15:0] SEED  = 16'h4ABA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xfer_req,
  input  logic        end_req,
  input  logic        cmd_clr,
  input  logic        dmack_n,
  input  logic        stop,
  input  logic        hstrobe,
  input  logic [15:0] dd,
  output logic        dmarq,
  output logic        dmardy_n,
  output logic        dmardy_oe,
  output logic        m_valid,
  output logic [15:0] m_data,
  input  logic        m_ready,
  output logic        crc_err,
  output logic [15:0] err_crc
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] HI_MARK = CW'(DEPTH - 3);

  logic          wr_en, rd_en, crc_seed, fifo_hi;
  logic [CW-1:0] count;
  logic [15:0]   crc_val;
  udma_st_e      st;

  assign m_valid = (count != '0);
  assign rd_en   = m_valid && m_ready;
  assign fifo_hi = (count > HI_MARK);

  udma_wr_ctrl #(.TRP(TRP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .end_req(end_req),
    .cmd_clr(cmd_clr), .dmack_n(dmack_n), .stop(stop), .hstrobe(hstrobe),
    .dd(dd), .fifo_hi(fifo_hi), .crc_val(crc_val), .dmarq(dmarq),
    .rdy_n(dmardy_n), .rdy_oe(dmardy_oe), .wr_en(wr_en), .crc_seed(crc_seed),
    .crc_err(crc_err), .err_crc(err_crc), .st(st)
  );

  udma_wr_crc #(.SEED(SEED)) u_crc (
    .clk(clk), .rst_n(rst_n), .seed_ld(crc_seed), .upd(wr_en),
    .word(dd), .crc(crc_val)
  );

  udma_wr_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(dd),
    .rd_en(rd_en), .rd_data(m_data), .count(count)
  );

  // R8: once waiting for the acknowledge, no strobe may move the CRC
  p_crc_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAITACK) |=> $stable(crc_val));
  p_hold_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
endmodule

// File: tb/udma_wr_dev_test.sv
`timescale 1ns/1ps
module udma_wr_dev_test;
  localparam int DEPTH = 8;
  localparam int TRP   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_req = 0, end_req = 0, cmd_clr = 0, dmack_n = 1, stop = 0, hstrobe = 0;
  logic [15:0] dd = '0;
  logic m_ready = 0;
  logic dmarq, dmardy_n, dmardy_oe, m_valid, crc_err;
  logic [15:0] m_data, err_crc;

  always #2 clk = ~clk;

  udma_wr_dev #(.DEPTH(DEPTH), .TRP(TRP), .SEED(16'h4ABA)) uut (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .end_req(end_req),
    .cmd_clr(cmd_clr), .dmack_n(dmack_n), .stop(stop), .hstrobe(hstrobe),
    .dd(dd), .dmarq(dmarq), .dmardy_n(dmardy_n), .dmardy_oe(dmardy_oe),
    .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready),
    .crc_err(crc_err), .err_crc(err_crc)
  );

  int n_run = 0, n_fail = 0;
  logic [15:0] exp_q [$];
  logic [15:0] bcrc;
  logic [15:0] first_bad;

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] r = c;
    for (int b = 0; b < 16; b++) begin
      if (r[15] != w[15-b]) r = (r << 1) ^ 16'h1021;
      else                  r = r << 1;
    end
    return r;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send_word(input logic [15:0] w);
    dd = w;
    hstrobe = ~hstrobe;
    exp_q.push_back(w);
    bcrc = ref_crc(bcrc, w);
    tick();
  endtask

  task automatic send_ignored();
    dd = 16'hDEAD;
    hstrobe = ~hstrobe;
    tick();
  endtask

  task automatic drain(input string req);
    m_ready = 1'b1;
    while (exp_q.size() != 0) begin
      chk(req, "m_valid", {31'd0, m_valid}, 32'd1);
      chk(req, "m_data", {16'd0, m_data}, {16'd0, exp_q[0]});
      void'(exp_q.pop_front());
      tick();
    end
    m_ready = 1'b0;
    chk(req, "empty after drain", {31'd0, m_valid}, 32'd0);
  endtask

  task automatic start_burst();
    xfer_req = 1'b1;
    tick();
    chk("R2", "dmarq up", {31'd0, dmarq}, 32'd1);
    xfer_req = 1'b0;
    dmack_n = 1'b0;
    bcrc = 16'h4ABA;
    tick();
    chk("R2", "ready driven", {30'd0, dmardy_oe, dmardy_n}, 32'b10);
  endtask

  task automatic finish(input logic [15:0] host_crc);
    chk("R11", "oe held before ack", {31'd0, dmardy_oe}, 32'd1);
    dd = host_crc;
    dmack_n = 1'b1;
    tick();
    chk("R11", "oe released", {31'd0, dmardy_oe}, 32'd0);
    stop = 1'b0;
  endtask

  task automatic dev_end();
    end_req = 1'b1;
    tick();
    end_req = 1'b0;
    chk("R6", "ready high, dmarq up", {30'd0, dmardy_n, dmarq}, 32'b11);
  endtask

  task automatic t_reset();
    chk("R1", "dmarq", {31'd0, dmarq}, 32'd0);
    chk("R1", "oe/ready", {30'd0, dmardy_oe, dmardy_n}, 32'b01);
    chk("R1", "valid/err", {30'd0, m_valid, crc_err}, 32'd0);
  endtask

  task automatic t_dev_term();
    start_burst();
    end_req = 1'b1;
    tick();
    end_req = 1'b0;
    chk("R5", "early end ignored", {30'd0, dmarq, dmardy_n}, 32'b10);
    send_word(16'h1234);
    send_word(16'hABCD);
    send_word(16'h0001);
    send_word(16'hFFFF);
    chk("R3", "words buffered", {31'd0, m_valid}, 32'd1);
    dev_end();
    send_word(16'h5A5A);
    for (int i = 0; i < TRP - 2; i++) tick();
    chk("R6", "dmarq before TRP", {31'd0, dmarq}, 32'd1);
    tick();
    chk("R6", "dmarq at TRP", {31'd0, dmarq}, 32'd0);
    send_ignored();
    drain("R3");
    chk("R8", "late edge dropped", {31'd0, m_valid}, 32'd0);
    finish(bcrc);
    chk("R9", "good crc", {31'd0, crc_err}, 32'd0);
  endtask

  task automatic t_pause_host_term();
    start_burst();
    for (int i = 0; i < DEPTH - 3; i++) send_word(16'(16'h0100 + i));
    chk("R4", "ready low at mark", {31'd0, dmardy_n}, 32'd0);
    send_word(16'h0200);
    chk("R4", "paused above mark", {31'd0, dmardy_n}, 32'd1);
    send_word(16'h0201);
    send_word(16'h0202);
    drain("R4");
    chk("R4", "resumed after drain", {31'd0, dmardy_n}, 32'd0);
    stop = 1'b1;
    tick();
    chk("R7", "stop response", {30'd0, dmarq, dmardy_n}, 32'b01);
    send_ignored();
    chk("R8", "final strobe dropped", {31'd0, m_valid}, 32'd0);
    first_bad = bcrc ^ 16'h0001;
    finish(first_bad);
    chk("R9", "mismatch flagged", {31'd0, crc_err}, 32'd1);
    chk("R10", "first value kept", {16'd0, err_crc}, {16'd0, first_bad});
  endtask

  task automatic t_sticky();
    start_burst();
    send_word(16'h7777);
    send_word(16'h8888);
    dev_end();
    for (int i = 0; i < TRP; i++) tick();
    finish(bcrc ^ 16'h8000);
    chk("R10", "flag stays", {31'd0, crc_err}, 32'd1);
    chk("R10", "no overwrite", {16'd0, err_crc}, {16'd0, first_bad});
    drain("R3");
    cmd_clr = 1'b1;
    tick();
    cmd_clr = 1'b0;
    chk("R10", "cleared", {31'd0, crc_err}, 32'd0);
  endtask

  task automatic t_seed();
    start_burst();
    send_word(16'h0F0F);
    send_word(16'hF0F0);
    send_word(16'h3C3C);
    stop = 1'b1;
    tick();
    send_ignored();
    finish(bcrc);
    chk("R9", "reseeded burst matches", {31'd0, crc_err}, 32'd0);
    drain("R3");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_dev_term();
    t_pause_host_term();
    t_sticky();
    t_seed();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule